// File: doc/BRIEF.md
# Immediate-Operand ALU Decoder

This execution unit handles the arithmetic and logical instructions of a 32-bit RISC core that take a 16-bit constant as their second operand. Each cycle it can accept one instruction word and the value already read from the source register. From the 6-bit major opcode in the top bits, it works out which operation to perform and how the constant is widened. It then produces the write-back value, the destination register index and a write strobe.

The unit claims only the eight opcodes 8 to 15. It still accepts any other opcode, but it raises a flag so that another unit can take the instruction, and it never writes anything for it. A write to register 0 is always dropped, because that register reads as zero.

Results come out one clock after an accepted input and carry a matching valid strobe. Overflow traps, the register file, memory accesses and branches belong to other units.

Top module: `ivx_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `wb_en` and `not_mine` are all low after that edge.
- R2: `out_valid` is high exactly one cycle after a cycle in which `in_valid` was high, and low otherwise. Back-to-back inputs produce back-to-back results in the same order.
- R3: Opcode 8 (add) and opcode 9 (add, unsigned form) sign-extend `instr[15:0]` and write the 32-bit sum with `rs_val`, wrapped modulo 2^32. Neither form traps.
- R4: Opcode 10 writes 1 when `rs_val` is less than the sign-extended immediate, both taken as two's-complement numbers, and writes 0 otherwise.
- R5: Opcode 11 first sign-extends the immediate, then compares it with `rs_val` as unsigned 32-bit numbers. It writes 1 if `rs_val` is lower and 0 otherwise.
- R6: Opcodes 12 (AND), 13 (OR) and 14 (XOR) zero-extend the immediate before the bitwise operation with `rs_val`.
- R7: Opcode 15 writes the immediate in bits [31:16] with zeros in bits [15:0], whatever the value of `rs_val`.
- R8: The destination index `wb_dest` is `instr[20:16]`. When that index is 0, `wb_en` stays low while `out_valid` still rises.
- R9: An opcode in `instr[31:26]` outside 8 to 15 sets `not_mine` with the result. For such an opcode, `wb_en` stays low and `wb_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operand are present this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the source register |
| out_valid | output | 1 | Result registers hold a new result |
| wb_data | output | 32 | Write-back value |
| wb_dest | output | 5 | Destination register index |
| wb_en | output | 1 | Register write strobe |
| not_mine | output | 1 | Opcode is outside this unit's group |

## Verification
On every cycle, the assertions check the following:
- the result valid follows the input valid by one cycle;
- a write strobe never targets register 0 and never comes with a foreign opcode;
- the two set-less-than results have zero in every bit above bit 0;
- a load-upper result has zero low half;
- reset clears the strobes.

The arithmetic itself can only be shown by the bench's scenarios, which compare the outputs with hand-worked values. These cases include:
- the sign-versus-zero extension choice per opcode;
- the wrap past 0x7FFFFFFF;
- the unsigned compare against a sign-extended constant, where 0xFFFF becomes the largest unsigned number;
- the fact that rs is ignored by load-upper.

// File: rtl/ivx_pkg.sv
`timescale 1ns/1ps
package ivx_pkg;
    // Operation selected by the low three opcode bits inside the group
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SLT  = 4'd2,
        OP_SLTU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_LUI  = 4'd7,
        OP_NONE = 4'd8
    } op_e;

    // How the short constant is widened
    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HIGH = 2'd2
    } ext_e;
endpackage

// File: rtl/ivx_decode.sv
`timescale 1ns/1ps
module ivx_decode
    import ivx_pkg::*;
#(
    parameter int OPC_W     = 6,
    parameter int GROUP_SEL = 1
) (
    input  logic [OPC_W-1:0] opcode,
    output op_e              op,
    output ext_e             ext,
    output logic             mine
);
    localparam int LOW_W = 3;

    always_comb begin
        mine = (opcode[OPC_W-1:LOW_W] == (OPC_W-LOW_W)'(GROUP_SEL));
        op   = OP_NONE;
        ext  = EXT_SIGN;
        if (mine) begin
            case (opcode[LOW_W-1:0])
                3'd0: op = OP_ADD;
                3'd1: op = OP_ADDU;
                3'd2: op = OP_SLT;
                3'd3: op = OP_SLTU;
                3'd4: op = OP_AND;
                3'd5: op = OP_OR;
                3'd6: op = OP_XOR;
                default: op = OP_LUI;
            endcase
            case (op)
                OP_AND, OP_OR, OP_XOR: ext = EXT_ZERO;
                OP_LUI:                ext = EXT_HIGH;
                default:               ext = EXT_SIGN;
            endcase
        end
    end

    always_comb begin
        assert_group_op_R9: assert (mine || op == OP_NONE);
    end
endmodule

// File: rtl/ivx_imm_ext.sv
`timescale 1ns/1ps
module ivx_imm_ext
    import ivx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  ext_e              ext,
    output logic [DATA_W-1:0] value
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        case (ext)
            EXT_ZERO: value = {{PAD_W{1'b0}}, imm};
            EXT_HIGH: value = {imm, {PAD_W{1'b0}}};
            default:  value = {{PAD_W{imm[IMM_W-1]}}, imm};
        endcase
    end

    always_comb begin
        assert_zero_ext_R6: assert (ext != EXT_ZERO || value[DATA_W-1:IMM_W] == '0);
    end
endmodule

// File: rtl/ivx_alu.sv
`timescale 1ns/1ps
module ivx_alu
    import ivx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (op)
            OP_ADD, OP_ADDU: result = a + b;
            OP_SLT:  result = DATA_W'($signed(a) < $signed(b));
            OP_SLTU: result = DATA_W'(a < b);
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_LUI:  result = b;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/ivx_top.sv
`timescale 1ns/1ps
module ivx_top
    import ivx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 16,
    parameter int REG_W     = 5,
    parameter int OPC_W     = 6,
    parameter int GROUP_SEL = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [31:0]       rs_val,
    output logic              out_valid,
    output logic [31:0]       wb_data,
    output logic [4:0]        wb_dest,
    output logic              wb_en,
    output logic              not_mine
);
    localparam int RT_LO  = IMM_W;
    localparam int RS_LO  = RT_LO + REG_W;
    localparam int OPC_LO = RS_LO + REG_W;

    typedef struct packed {
        logic              vld;
        logic              en;
        logic              foreign;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] data;
        op_e               op;
    } res_t;

    res_t res_d, res_q;
    op_e               dec_op;
    ext_e              dec_ext;
    logic              dec_mine;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] alu_res;
    logic [REG_W-1:0]  rt_idx;
    logic              unused_rs_bits;

    assign rt_idx         = instr[RT_LO +: REG_W];
    assign unused_rs_bits = ^instr[RS_LO +: REG_W];

    ivx_decode #(.OPC_W(OPC_W), .GROUP_SEL(GROUP_SEL)) u_dec (
        .opcode (instr[OPC_LO +: OPC_W]),
        .op     (dec_op),
        .ext    (dec_ext),
        .mine   (dec_mine)
    );

    ivx_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm   (instr[IMM_W-1:0]),
        .ext   (dec_ext),
        .value (imm_val)
    );

    ivx_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (dec_op),
        .a      (rs_val),
        .b      (imm_val),
        .result (alu_res)
    );

    always_comb begin
        res_d         = res_q;
        res_d.vld     = in_valid;
        res_d.en      = 1'b0;
        res_d.foreign = 1'b0;
        if (in_valid) begin
            res_d.foreign = !dec_mine;
            res_d.en      = dec_mine && (rt_idx != '0);
            res_d.dest    = rt_idx;
            res_d.data    = dec_mine ? alu_res : '0;
            res_d.op      = dec_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{vld: 1'b0, en: 1'b0, foreign: 1'b0, dest: '0,
                       data: '0, op: OP_NONE};
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign wb_en     = res_q.en;
    assign not_mine  = res_q.foreign;
    assign wb_dest   = res_q.dest;
    assign wb_data   = res_q.data;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !wb_en && !not_mine));
    assert_latency_one_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wb_en));
    assert_set_is_bool_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (res_q.op == OP_SLT || res_q.op == OP_SLTU))
            |-> wb_data[DATA_W-1:1] == '0);
    assert_upper_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_q.op == OP_LUI) |-> wb_data[IMM_W-1:0] == '0);
    assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_dest != '0 && out_valid));
    assert_foreign_silent_R9: assert property (@(posedge clk) disable iff (rst)
        not_mine |-> (!wb_en && wb_data == '0 && out_valid));
endmodule

// File: tb/tb_ivx_top.sv
`timescale 1ns/1ps
module tb_ivx_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [31:0] rs_val;
    logic        out_valid;
    logic [31:0] wb_data;
    logic [4:0]  wb_dest;
    logic        wb_en;
    logic        not_mine;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    ivx_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .out_valid(out_valid), .wb_data(wb_data),
        .wb_dest(wb_dest), .wb_en(wb_en), .not_mine(not_mine)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rt,
                                       input logic [15:0] imm);
        return {opc, 5'd3, rt, imm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one instruction, then sample the registered result at the next falling edge
    task automatic issue(input logic [31:0] iw, input logic [31:0] rv);
        in_valid = 1'b1; instr = iw; rs_val = rv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [4:0] rt, input logic [31:0] exp);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " en"}, 32'(wb_en), 32'd1);
        check({req, " dest"}, 32'(wb_dest), 32'(rt));
        check({req, " data"}, wb_data, exp);
    endtask

    task automatic t_reset_R1;
        rst = 1'b1; in_valid = 1'b1; instr = mk(6'd8, 5'd4, 16'h0001); rs_val = 32'd1;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 en", 32'(wb_en), 32'd0);
        check("R1 not_mine", 32'(not_mine), 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_add_R3;
        issue(mk(6'd8, 5'd7, 16'hFFFF), 32'd5);
        expect_write("R3 add neg imm", 5'd7, 32'd4);
        issue(mk(6'd8, 5'd7, 16'h0001), 32'h7FFF_FFFF);
        expect_write("R3 add wrap", 5'd7, 32'h8000_0000);
        issue(mk(6'd9, 5'd17, 16'h8000), 32'd0);
        expect_write("R3 addu sign ext", 5'd17, 32'hFFFF_8000);
    endtask

    task automatic t_slt_R4;
        issue(mk(6'd10, 5'd2, 16'h0000), 32'hFFFF_FFFF);
        expect_write("R4 slt -1<0", 5'd2, 32'd1);
        issue(mk(6'd10, 5'd2, 16'hFFFF), 32'd5);
        expect_write("R4 slt 5<-1", 5'd2, 32'd0);
    endtask

    task automatic t_sltu_R5;
        issue(mk(6'd11, 5'd9, 16'hFFFF), 32'd5);
        expect_write("R5 sltu vs max", 5'd9, 32'd1);
        issue(mk(6'd11, 5'd9, 16'h8000), 32'hFFFF_0000);
        expect_write("R5 sltu high", 5'd9, 32'd1);
        issue(mk(6'd11, 5'd9, 16'hFFFF), 32'hFFFF_FFFF);
        expect_write("R5 sltu equal", 5'd9, 32'd0);
    endtask

    task automatic t_logic_R6;
        issue(mk(6'd12, 5'd30, 16'h8F0F), 32'hFFFF_FFFF);
        expect_write("R6 and", 5'd30, 32'h0000_8F0F);
        issue(mk(6'd13, 5'd30, 16'h8001), 32'h1234_0000);
        expect_write("R6 or", 5'd30, 32'h1234_8001);
        issue(mk(6'd14, 5'd30, 16'hFFFF), 32'hFFFF_0000);
        expect_write("R6 xor", 5'd30, 32'hFFFF_FFFF);
    endtask

    task automatic t_lui_R7;
        issue(mk(6'd15, 5'd31, 16'hABCD), 32'hFFFF_FFFF);
        expect_write("R7 lui", 5'd31, 32'hABCD_0000);
    endtask

    task automatic t_r0_R8;
        issue(mk(6'd8, 5'd0, 16'h0010), 32'd1);
        check("R8 valid", 32'(out_valid), 32'd1);
        check("R8 en", 32'(wb_en), 32'd0);
        check("R8 dest", 32'(wb_dest), 32'd0);
    endtask

    task automatic t_foreign_R9;
        logic [5:0] codes [3] = '{6'd0, 6'd16, 6'd35};
        foreach (codes[k]) begin
            issue(mk(codes[k], 5'd6, 16'h1234), 32'h5555_5555);
            check("R9 valid", 32'(out_valid), 32'd1);
            check("R9 not_mine", 32'(not_mine), 32'd1);
            check("R9 en", 32'(wb_en), 32'd0);
            check("R9 data", wb_data, 32'd0);
        end
        issue(mk(6'd13, 5'd6, 16'h0001), 32'd0);
        check("R9 own clears flag", 32'(not_mine), 32'd0);
    endtask

    task automatic t_stream_R2;
        in_valid = 1'b1; instr = mk(6'd8, 5'd1, 16'd1); rs_val = 32'd10;
        @(negedge clk);
        check("R2 first valid", 32'(out_valid), 32'd1);
        check("R2 first data", wb_data, 32'd11);
        instr = mk(6'd15, 5'd2, 16'h0002); rs_val = 32'd0;
        @(negedge clk);
        check("R2 second data", wb_data, 32'h0002_0000);
        check("R2 second dest", 32'(wb_dest), 32'd2);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 32'd0);
        check("R2 idle en", 32'(wb_en), 32'd0);
    endtask

    initial begin
        in_valid = 1'b0; instr = '0; rs_val = '0; rst = 1'b1;
        @(negedge clk);
        t_reset_R1;
        t_add_R3;
        t_slt_R4;
        t_sltu_R5;
        t_logic_R6;
        t_lui_R7;
        t_r0_R8;
        t_foreign_R9;
        t_stream_R2;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule